// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Signed Compare

This block is a purely combinational integer ALU for a simple processor datapath. It takes two operands and a three-bit operation code. It returns a result word together with three flags: carry out, zero and signed overflow. The operations are bitwise AND, bitwise OR, addition, subtraction and signed set-on-less-than.

The datapath is a row of identical one-bit slices. Each slice forms AND, OR and a full-adder sum side by side. A four-way selector then picks one of those, or a separate "less" input. Carries ripple from slice to slice. The top operation bit has two jobs: it inverts B in every slice and it is the carry into slice 0, so one adder serves both addition and subtraction. The signed comparison uses the sign of the difference, corrected by the overflow condition. Only the lowest slice receives the comparison result on its less input; every other slice sees zero there.

Top module: `alu_ripple_top`

## Requirements
- R1: With op 000 the result is A AND B. With op 001 the result is A OR B. The low two op bits select the slice output: 00 AND, 01 OR, 10 sum, 11 less.
- R2: With op 010 the result is (A + B) mod 2^32, and CarryOut is bit 32 of the unsigned sum.
- R3: With op 110 the result is (A - B) mod 2^32, computed as A + ~B + 1. CarryOut is 1 exactly when A >= B taken as unsigned numbers.
- R4: With op 111, result bit 0 is 1 exactly when A < B as signed two's-complement numbers, and bits 31..1 are 0. This holds even when A - B overflows.
- R5: Overflow and CarryOut always describe the adder for the current op. When op bit 2 = 0, Overflow is 1 exactly when A and B have the same sign and the sum's sign differs. When op bit 2 = 1, Overflow is 1 exactly when A and B differ in sign and the difference's sign differs from A's sign.
- R6: Zero is 1 exactly when all 32 result bits are 0, for every op code.
- R7: With op 100 the result is A AND NOT B. With op 101 the result is A OR NOT B. In both cases B is inverted by op bit 2.
- R8: With op 011, result bit 0 is the sign of the exact, unwrapped signed sum A + B, and bits 31..1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 32 | Operand A |
| opb_i | input | 32 | Operand B |
| op_i | input | 3 | Operation code; bit 2 inverts B and is the carry-in, bits 1..0 select the slice output |
| result_o | output | 32 | Selected result word |
| carry_o | output | 1 | Carry out of the top slice |
| zero_o | output | 1 | High when every result bit is 0 |
| overflow_o | output | 1 | Signed overflow of the addition or subtraction |

## Verification
The block holds no state, so any internal fault appears at the ports in the same evaluation as the stimulus. A wrong value at one point of the carry chain corrupts every higher sum bit, CarryOut and possibly Overflow. Operand pairs such as all-ones plus one, which propagate a carry across the whole word, therefore expose it at once. A wrong less routing or a wrong overflow correction shows only in bit 0 of a compare result. The comparison is therefore exercised with operand pairs whose difference overflows in both directions, and with pairs where it does not.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int unsigned OP_W  = 3;
  localparam int unsigned SEL_W = 2;

  // Slice output selector, driven by the low op bits
  typedef enum logic [SEL_W-1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } slice_sel_e;

  // Operation codes used by the datapath
  localparam logic [OP_W-1:0] OP_AND = 3'b000;
  localparam logic [OP_W-1:0] OP_OR  = 3'b001;
  localparam logic [OP_W-1:0] OP_ADD = 3'b010;
  localparam logic [OP_W-1:0] OP_SUB = 3'b110;
  localparam logic [OP_W-1:0] OP_SLT = 3'b111;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic             a_i,
  input  logic             b_i,
  input  logic             b_inv_i,
  input  logic             carry_i,
  input  logic             less_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             sum_o,
  output logic             carry_o,
  output logic             res_o
);

  logic b_eff;
  logic and_bit;
  logic or_bit;
  logic half_sum;

  always_comb begin
    b_eff    = b_i ^ b_inv_i;
    and_bit  = a_i & b_eff;
    or_bit   = a_i | b_eff;
    half_sum = a_i ^ b_eff;
    sum_o    = half_sum ^ carry_i;
    carry_o  = and_bit | (half_sum & carry_i);
  end

  always_comb begin
    unique case (slice_sel_e'(sel_i))
      SEL_AND:  res_o = and_bit;
      SEL_OR:   res_o = or_bit;
      SEL_SUM:  res_o = sum_o;
      SEL_LESS: res_o = less_i;
      default:  res_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  output logic             zero_o
);

  logic any_set;

  always_comb begin
    any_set = 1'b0;
    for (int i = 0; i < WIDTH; i++) begin
      any_set = any_set | word_i[i];
    end
    zero_o = ~any_set;
  end

endmodule

// File: rtl/alu_sign_unit.sv
module alu_sign_unit (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic b_inv_i,
  input  logic sum_msb_i,
  output logic overflow_o,
  output logic less_o
);

  logic b_eff_msb;

  always_comb begin
    b_eff_msb  = b_msb_i ^ b_inv_i;
    // Same-sign adder inputs whose sum flips sign
    overflow_o = ~(a_msb_i ^ b_eff_msb) & (sum_msb_i ^ a_msb_i);
    // Sign of the true result, corrected when the adder wrapped
    less_o     = sum_msb_i ^ overflow_o;
  end

endmodule

// File: rtl/alu_ripple_top.sv
module alu_ripple_top
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] opa_i,
  input  logic [WIDTH-1:0] opb_i,
  input  logic [OP_W-1:0]  op_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o,
  output logic             zero_o,
  output logic             overflow_o
);

  localparam int unsigned MSB = WIDTH - 1;

  logic             b_invert;
  logic [SEL_W-1:0] slice_sel;
  logic [WIDTH:0]   carry_chain;
  logic [WIDTH-1:0] sum_raw;
  logic [WIDTH-1:0] less_vec;
  logic             set_less;

  assign b_invert       = op_i[OP_W-1];
  assign slice_sel      = op_i[SEL_W-1:0];
  assign carry_chain[0] = b_invert;
  assign less_vec       = {{(WIDTH-1){1'b0}}, set_less};

  for (genvar g = 0; g < WIDTH; g++) begin : g_slice
    alu_bit_slice u_slice (
      .a_i     (opa_i[g]),
      .b_i     (opb_i[g]),
      .b_inv_i (b_invert),
      .carry_i (carry_chain[g]),
      .less_i  (less_vec[g]),
      .sel_i   (slice_sel),
      .sum_o   (sum_raw[g]),
      .carry_o (carry_chain[g+1]),
      .res_o   (result_o[g])
    );
  end

  alu_sign_unit u_sign (
    .a_msb_i    (opa_i[MSB]),
    .b_msb_i    (opb_i[MSB]),
    .b_inv_i    (b_invert),
    .sum_msb_i  (sum_raw[MSB]),
    .overflow_o (overflow_o),
    .less_o     (set_less)
  );

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .word_i (result_o),
    .zero_o (zero_o)
  );

  assign carry_o = carry_chain[WIDTH];

endmodule

// File: rtl/alu_ripple_checker.sv
module alu_ripple_checker
  import alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] opa_i,
  input logic [WIDTH-1:0] opb_i,
  input logic [OP_W-1:0]  op_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o,
  input logic             zero_o,
  input logic             overflow_o
);

  always_comb begin
    AST_ZERO_MATCH: assert (zero_o == (result_o == '0)); // R6
    if (op_i == OP_AND) begin
      AST_AND_SUBSET: assert ((result_o & ~opa_i) == '0); // R1
    end
    if (op_i == OP_OR) begin
      AST_OR_SUPERSET: assert ((result_o & opa_i) == opa_i); // R1
    end
    if (op_i == OP_ADD) begin
      AST_ADD_SUM: assert ({carry_o, result_o} == ({1'b0, opa_i} + {1'b0, opb_i})); // R2
      if (opa_i[WIDTH-1] != opb_i[WIDTH-1]) begin
        AST_ADD_NO_OVERFLOW: assert (!overflow_o); // R5
      end
    end
    if (op_i == OP_SUB) begin
      AST_SUB_INVERSE: assert ((result_o + opb_i) == opa_i); // R3
      AST_SUB_BORROW: assert (carry_o == (opa_i >= opb_i)); // R3
    end
    if (op_i[SEL_W-1:0] == 2'b11) begin
      AST_LESS_UPPER_CLEAR: assert (result_o[WIDTH-1:1] == '0); // R4
    end
  end

endmodule

bind alu_ripple_top alu_ripple_checker #(.WIDTH(WIDTH)) i_alu_ripple_checker (.*);

// File: tb/test_alu_ripple_top.sv
module test_alu_ripple_top;

  localparam int W = 32;
  localparam logic [W-1:0] MAXP = 32'h7FFF_FFFF;
  localparam logic [W-1:0] MINN = 32'h8000_0000;
  localparam logic [W-1:0] ONES = 32'hFFFF_FFFF;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [2:0]   op;
  logic [W-1:0] result;
  logic         carry;
  logic         zero;
  logic         overflow;

  int checks;
  int failures;

  alu_ripple_top #(.WIDTH(W)) i_alu_ripple_top (
    .opa_i      (opa),
    .opb_i      (opb),
    .op_i       (op),
    .result_o   (result),
    .carry_o    (carry),
    .zero_o     (zero),
    .overflow_o (overflow)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model built from the requirement text
  task automatic model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] o,
                       output logic [W-1:0] r, output logic c, output logic z, output logic v);
    logic [W-1:0] be;
    logic [W:0]   s;
    logic [W:0]   exact;
    be = o[2] ? ~b : b;
    s  = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, o[2]};
    c  = s[W];
    if (o[2]) v = (a[W-1] != b[W-1]) && (s[W-1] != a[W-1]);
    else      v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
    case (o[1:0])
      2'b00: r = a & be;
      2'b01: r = a | be;
      2'b10: r = s[W-1:0];
      default: begin
        if (o[2]) r = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
        else begin
          exact = {a[W-1], a} + {b[W-1], b};
          r = {{(W-1){1'b0}}, exact[W]};
        end
      end
    endcase
    z = (r == '0);
  endtask

  task automatic apply_check(input string tag, input logic [W-1:0] a, input logic [W-1:0] b,
                             input logic [2:0] o);
    logic [W-1:0] er;
    logic ec, ez, ev;
    @(posedge clk);
    opa = a; opb = b; op = o;
    @(negedge clk);
    model(a, b, o, er, ec, ez, ev);
    checks++;
    if (result !== er || carry !== ec || zero !== ez || overflow !== ev) begin
      failures++;
      $display("FAIL %s op=%b a=%h b=%h actual r=%h c=%b z=%b v=%b expected r=%h c=%b z=%b v=%b",
               tag, o, a, b, result, carry, zero, overflow, er, ec, ez, ev);
    end
  endtask

  task automatic t_reset_state();
    // R6: idle inputs after reset give a zero result with Zero set
    apply_check("R6", '0, '0, 3'b000);
  endtask

  task automatic t_logic_ops();
    apply_check("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 3'b000);
    apply_check("R1", 32'hF0F0_1234, 32'h0FF0_FF00, 3'b001);
    apply_check("R1", 32'hAAAA_AAAA, 32'h5555_5555, 3'b000);
    apply_check("R1", '0, '0, 3'b001);
  endtask

  task automatic t_add();
    apply_check("R2", 32'd1234, 32'd4321, 3'b010);
    apply_check("R2", ONES, 32'd1, 3'b010);
    apply_check("R2", ONES, ONES, 3'b010);
    apply_check("R5", MAXP, 32'd1, 3'b010);
    apply_check("R5", MINN, MINN, 3'b010);
    apply_check("R5", MAXP, MINN, 3'b010);
  endtask

  task automatic t_sub();
    apply_check("R3", 32'd100, 32'd7, 3'b110);
    apply_check("R3", 32'd7, 32'd100, 3'b110);
    apply_check("R3", 32'h1234_5678, 32'h1234_5678, 3'b110);
    apply_check("R3", '0, ONES, 3'b110);
    apply_check("R5", MINN, 32'd1, 3'b110);
    apply_check("R5", MAXP, ONES, 3'b110);
  endtask

  task automatic t_slt();
    apply_check("R4", 32'd3, 32'd5, 3'b111);
    apply_check("R4", 32'd5, 32'd3, 3'b111);
    apply_check("R4", ONES, 32'd0, 3'b111);
    apply_check("R4", MINN, MAXP, 3'b111);
    apply_check("R4", MAXP, MINN, 3'b111);
    apply_check("R4", MINN, MINN, 3'b111);
  endtask

  task automatic t_spare_codes();
    apply_check("R7", 32'hFF00_FF00, 32'h0F0F_0F0F, 3'b100);
    apply_check("R7", 32'h0000_00F0, 32'hFFFF_FF0F, 3'b101);
    apply_check("R8", MAXP, 32'd1, 3'b011);
    apply_check("R8", MINN, ONES, 3'b011);
    apply_check("R8", 32'd5, 32'hFFFF_FFF0, 3'b011);
  endtask

  task automatic t_corners();
    logic [W-1:0] vals [4];
    logic [2:0]   ops  [5];
    vals[0] = '0; vals[1] = ONES; vals[2] = MAXP; vals[3] = MINN;
    ops[0] = 3'b000; ops[1] = 3'b001; ops[2] = 3'b010; ops[3] = 3'b110; ops[4] = 3'b111;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        for (int k = 0; k < 5; k++)
          apply_check("R5_corner", vals[i], vals[j], ops[k]);
  endtask

  task automatic t_random();
    for (int n = 0; n < 400; n++) begin
      apply_check("R2_R3_R4_random", $urandom(), $urandom(), 3'($urandom_range(0, 7)));
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    opa = '0; opb = '0; op = 3'b000;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_logic_ops();
    t_add();
    t_sub();
    t_slt();
    t_spare_codes();
    t_corners();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule